// File: doc/BRIEF.md
# Serial Sampling ADC Host Controller

This block sits on the host side of a three-wire link to a fast serial sampling converter. It generates a free-running serial clock and a conversion-start strobe. It shifts in the 16-bit frame that the converter returns on its data line during each conversion. From each frame it extracts a 12-bit sample and a reference-settled flag, and presents them with a one-clock valid strobe. One frame spans sixteen serial-clock periods, so the sample rate is always one sixteenth of the serial-clock rate.

The block also manages the converter's two low-power states. A light state keeps the reference running, and a deep state also powers the reference down. To enter either state it holds the serial clock low and sends a counted burst of conversion-start pulses. To leave it, it restarts the serial clock, which wakes the converter. It then waits a settling time that depends on the state being left, and only after that does it start frames again. After a deep-state wake, samples are suppressed until a frame reports that the reference has settled. Requests to change the power state are acted on only at a frame boundary. A stop request lets the frame in flight finish.

Top module: `adc_host_ctrl`

## Requirements
- R1: While rst_n is low, adc_sck_o, adc_conv_o and smp_valid_o are low and pwr_mode_o reads 0 (active).
- R2: With run_i high and the converter active, adc_conv_o is high for exactly one serial-clock period (2*HALF_DIV clocks) at the start of each frame. Frames follow back to back, so rising edges of adc_conv_o are 16 serial-clock periods apart, and adc_conv_o only changes while adc_sck_o is low.
- R3: The frame arrives most significant bit first. smp_data_o carries frame bits 13 down to 2, smp_ref_rdy_o carries frame bit 1, and smp_valid_o is a single-clock pulse once per delivered frame.
- R4: When run_i falls in the middle of a frame, that frame is still delivered, and no further conversion-start pulse follows.
- R5: A pwr_req_i value of 1 (light low-power) produces two conversion-start pulses, each one serial-clock period wide, with one idle period between them and adc_sck_o held low. pwr_mode_o then reads 1.
- R6: A pwr_req_i value of 2 (deep low-power) produces four such pulses, after which pwr_mode_o reads 2.
- R7: In either low-power state adc_sck_o and adc_conv_o stay low and run_i is ignored. A request for the other low-power state is also ignored.
- R8: An active request (pwr_req_i 0) in a low-power state returns pwr_mode_o to 0 and restarts adc_sck_o. No conversion-start pulse follows for at least ceil(CLK_MHZ*NAP_NS/1000) clocks after a light-state wake, or CLK_MHZ*SLEEP_US clocks after a deep-state wake.
- R9: After a deep-state wake, frames whose ready flag (bit 1) is 0 raise no smp_valid_o. From the first frame with the flag set, every frame is delivered again, whatever its flag.
- R10: A low-power request made during a frame takes effect only when that frame ends, and that frame is delivered.
- R11: A pwr_req_i value of 3 is treated as an active request. It has no effect while active and wakes the converter from a low-power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High to convert continuously, low to stop at the next frame end |
| pwr_req_i | input | 2 | Requested power state: 0 active, 1 light low-power, 2 deep low-power, 3 active |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_sck_o | output | 1 | Serial clock to the converter |
| adc_conv_o | output | 1 | Conversion-start strobe and power-down pulse line |
| smp_valid_o | output | 1 | One-clock strobe marking a new sample |
| smp_data_o | output | 12 | Extracted sample |
| smp_ref_rdy_o | output | 1 | Reference-settled flag of the delivered frame |
| pwr_mode_o | output | 2 | Current converter power state, same encoding as pwr_req_i |

## Verification
The bench makes a low-power request partway through a frame. A controller that acted on it at once would cut the frame short, lose its sample and pulse the start line while the converter is still shifting. The bench counts the pulses in each power-down burst and measures their width and spacing, because an off-by-one burst leaves the converter in the wrong state without any sign of it. It times the first conversion after each wake against both settling windows, so a timer that ends early or picks the wrong length shows up. After a deep-state wake it feeds frames with the ready flag clear and then set. This exposes a gate that never opens, one that lets unsettled samples through, and one that stays shut after the first good frame.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;
   typedef enum logic [1:0] {
      PWR_ACT   = 2'd0,
      PWR_NAP   = 2'd1,
      PWR_SLEEP = 2'd2
   } pwr_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FRAME,
      ST_BURST,
      ST_LOW,
      ST_WAIT
   } ctl_state_e;
endpackage

// File: rtl/adc_sck_gen.sv
`timescale 1ns/1ps
module adc_sck_gen #(
   parameter int HALF_DIV     = 2,
   parameter bit RISE_CAPTURE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic sck_on,
   output logic sck_o,
   output logic per_end_o,
   output logic cap_tick_o
);
   localparam int CNT_W = (2 * HALF_DIV > 2) ? $clog2(2 * HALF_DIV) : 1;
   localparam logic [CNT_W-1:0] C_LAST = CNT_W'(2 * HALF_DIV - 1);
   localparam logic [CNT_W-1:0] C_HALF = CNT_W'(HALF_DIV);
   localparam logic [CNT_W-1:0] C_PRE  = CNT_W'(HALF_DIV - 1);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("adc_sck_gen: HALF_DIV must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (!run_en || cnt_q == C_LAST) cnt_q <= '0;
      else                              cnt_q <= cnt_q + 1'b1;
   end

   assign sck_o     = run_en && sck_on && (cnt_q >= C_HALF);
   assign per_end_o = run_en && (cnt_q == C_LAST);

   if (RISE_CAPTURE) begin : g_rise
      assign cap_tick_o = run_en && (cnt_q == C_PRE);
   end else begin : g_fall
      assign cap_tick_o = run_en && (cnt_q == C_LAST);
   end

   // R2
   sck_low_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (per_end_o && run_en) |=> !sck_o);
endmodule

// File: rtl/adc_frame_rx.sv
`timescale 1ns/1ps
module adc_frame_rx #(
   parameter int FRAME_BITS = 16,
   parameter int SAMPLE_W   = 12,
   parameter int SAMPLE_LSB = 2,
   parameter int RDY_POS    = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_en,
   input  logic                cap_last,
   input  logic                sdo_i,
   output logic                done_o,
   output logic [SAMPLE_W-1:0] sample_o,
   output logic                rdy_o
);
   localparam int KEEP_W = SAMPLE_LSB + SAMPLE_W;

   if (KEEP_W > FRAME_BITS || KEEP_W < 2) begin : g_bad_fit
      $error("adc_frame_rx: sample field does not fit the frame");
   end
   if (RDY_POS >= SAMPLE_LSB) begin : g_bad_rdy
      $error("adc_frame_rx: ready flag must sit below the sample field");
   end

   logic [KEEP_W-1:0] shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= cap_en && cap_last;
         if (cap_en) shreg_q <= {shreg_q[KEEP_W-2:0], sdo_i};
      end
   end

   assign sample_o = shreg_q[SAMPLE_LSB +: SAMPLE_W];
   assign rdy_o    = shreg_q[RDY_POS];

   // R3
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: rtl/adc_wake_timer.sv
`timescale 1ns/1ps
module adc_wake_timer #(
   parameter int NAP_CYC   = 60,
   parameter int SLEEP_CYC = 2000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic long_i,
   output logic done_o
);
   localparam int MAX_C = (SLEEP_CYC > NAP_CYC) ? SLEEP_CYC : NAP_CYC;
   localparam int CW    = $clog2(MAX_C + 1);
   localparam logic [CW-1:0] NAP_V = CW'(NAP_CYC);
   localparam logic [CW-1:0] SLP_V = CW'(SLEEP_CYC);

   if (NAP_CYC < 1 || SLEEP_CYC < 1) begin : g_bad_wait
      $error("adc_wake_timer: wait lengths must be at least one clock");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= long_i ? SLP_V : NAP_V;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   // R8
   wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/adc_host_ctrl.sv
`timescale 1ns/1ps
module adc_host_ctrl
   import adc_host_pkg::*;
#(
   parameter int FRAME_BITS   = 16,
   parameter int SAMPLE_W     = 12,
   parameter int SAMPLE_LSB   = 2,
   parameter int RDY_POS      = 1,
   parameter int HALF_DIV     = 2,
   parameter bit RISE_CAPTURE = 1'b1,
   parameter int NAP_PULSES   = 2,
   parameter int SLEEP_PULSES = 4,
   parameter int CLK_MHZ      = 200,
   parameter int NAP_NS       = 300,
   parameter int SLEEP_US     = 10000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run_i,
   input  logic [1:0]          pwr_req_i,
   input  logic                adc_sdo_i,
   output logic                adc_sck_o,
   output logic                adc_conv_o,
   output logic                smp_valid_o,
   output logic [SAMPLE_W-1:0] smp_data_o,
   output logic                smp_ref_rdy_o,
   output logic [1:0]          pwr_mode_o
);
   localparam int NAP_CYC   = (CLK_MHZ * NAP_NS + 999) / 1000;
   localparam int SLEEP_CYC = CLK_MHZ * SLEEP_US;
   localparam int BIT_W     = $clog2(FRAME_BITS);
   localparam logic [BIT_W-1:0] FRAME_LAST = BIT_W'(FRAME_BITS - 1);
   localparam logic [BIT_W-1:0] NAP_LAST   = BIT_W'(2 * NAP_PULSES - 1);
   localparam logic [BIT_W-1:0] SLEEP_LAST = BIT_W'(2 * SLEEP_PULSES - 1);

   if (NAP_PULSES < 1 || 2 * NAP_PULSES > FRAME_BITS ||
       SLEEP_PULSES < 1 || 2 * SLEEP_PULSES > FRAME_BITS) begin : g_bad_burst
      $error("adc_host_ctrl: pulse burst must fit in one frame counter");
   end

   ctl_state_e       state_q, bnd_state;
   pwr_mode_e        tgt_q, mode_q, req_mode;
   logic [BIT_W-1:0] bidx_q, burst_last;
   logic             req_low, wake_load, ref_wait_q;
   logic             pend, cap_tick, cap_en, timer_done;
   logic             frame_done, rdy_w;
   logic [SAMPLE_W-1:0] smp_w;

   assign req_low    = (pwr_req_i == 2'd1) || (pwr_req_i == 2'd2);
   assign req_mode   = (pwr_req_i == 2'd2) ? PWR_SLEEP : PWR_NAP;
   assign wake_load  = (state_q == ST_LOW) && !req_low;
   assign burst_last = (tgt_q == PWR_SLEEP) ? SLEEP_LAST : NAP_LAST;

   always_comb begin
      if (req_low)    bnd_state = ST_BURST;
      else if (run_i) bnd_state = ST_FRAME;
      else            bnd_state = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bidx_q  <= '0;
         tgt_q   <= PWR_NAP;
         mode_q  <= PWR_ACT;
      end else begin
         unique case (state_q)
            ST_IDLE: if (pend) begin
               state_q <= bnd_state;
               tgt_q   <= req_mode;
               bidx_q  <= '0;
            end
            ST_FRAME: if (pend) begin
               if (bidx_q == FRAME_LAST) begin
                  state_q <= bnd_state;
                  tgt_q   <= req_mode;
                  bidx_q  <= '0;
               end else begin
                  bidx_q <= bidx_q + 1'b1;
               end
            end
            ST_BURST: if (pend) begin
               if (bidx_q == burst_last) begin
                  state_q <= ST_LOW;
                  mode_q  <= tgt_q;
                  bidx_q  <= '0;
               end else begin
                  bidx_q <= bidx_q + 1'b1;
               end
            end
            ST_LOW: if (wake_load) begin
               state_q <= ST_WAIT;
               mode_q  <= PWR_ACT;
            end
            ST_WAIT: if (pend && timer_done) begin
               state_q <= bnd_state;
               tgt_q   <= req_mode;
               bidx_q  <= '0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   adc_sck_gen #(.HALF_DIV(HALF_DIV), .RISE_CAPTURE(RISE_CAPTURE)) u_sck (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (state_q != ST_LOW),
      .sck_on     (state_q != ST_BURST),
      .sck_o      (adc_sck_o),
      .per_end_o  (pend),
      .cap_tick_o (cap_tick)
   );

   adc_wake_timer #(.NAP_CYC(NAP_CYC), .SLEEP_CYC(SLEEP_CYC)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (wake_load),
      .long_i (mode_q == PWR_SLEEP),
      .done_o (timer_done)
   );

   assign cap_en = cap_tick && (state_q == ST_FRAME);

   adc_frame_rx #(.FRAME_BITS(FRAME_BITS), .SAMPLE_W(SAMPLE_W),
                  .SAMPLE_LSB(SAMPLE_LSB), .RDY_POS(RDY_POS)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_last (bidx_q == FRAME_LAST),
      .sdo_i    (adc_sdo_i),
      .done_o   (frame_done),
      .sample_o (smp_w),
      .rdy_o    (rdy_w)
   );

   assign adc_conv_o = ((state_q == ST_FRAME) && (bidx_q == '0)) ||
                       ((state_q == ST_BURST) && !bidx_q[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_wait_q    <= 1'b0;
         smp_valid_o   <= 1'b0;
         smp_data_o    <= '0;
         smp_ref_rdy_o <= 1'b0;
      end else begin
         if (wake_load && mode_q == PWR_SLEEP) ref_wait_q <= 1'b1;
         else if (frame_done && rdy_w)         ref_wait_q <= 1'b0;
         smp_valid_o <= frame_done && (!ref_wait_q || rdy_w);
         if (frame_done) begin
            smp_data_o    <= smp_w;
            smp_ref_rdy_o <= rdy_w;
         end
      end
   end

   assign pwr_mode_o = mode_q;

   // R7
   lowpwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != PWR_ACT) |-> (!adc_conv_o && !adc_sck_o));
   // R5
   burst_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BURST) |-> !adc_sck_o);
   // R2
   conv_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(adc_conv_o) || $fell(adc_conv_o)) |-> !adc_sck_o);
   // R8
   wake_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_conv_o) |-> timer_done);
   // R3
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid_o |=> !smp_valid_o);
   // R9
   ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid_o && $past(ref_wait_q)) |-> smp_ref_rdy_o);
endmodule

// File: tb/adc_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_host_ctrl_tb_top;
   localparam int PER     = 4;      // serial-clock period in clocks
   localparam int FRM     = 16 * PER;
   localparam int NAP_W   = 60;     // ceil(200*300/1000)
   localparam int SLEEP_W = 1000;   // 200*5

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run = 1'b0;
   logic [1:0] preq = 2'd0;
   logic sdo = 1'b0;
   logic sck, conv, vld, rdy;
   logic [11:0] data;
   logic [1:0] mode;

   always #2.5 clk = ~clk;

   adc_host_ctrl #(.SLEEP_US(5)) dut_i (
      .clk(clk), .rst_n(rst_n), .run_i(run), .pwr_req_i(preq),
      .adc_sdo_i(sdo), .adc_sck_o(sck), .adc_conv_o(conv),
      .smp_valid_o(vld), .smp_data_o(data), .smp_ref_rdy_o(rdy),
      .pwr_mode_o(mode)
   );

   int n_chk = 0, n_bad = 0;
   int cyc = 0, conv_rise = 0, sck_rise = 0, vld_cnt = 0;
   int rise_cyc = 0, prev_rise_cyc = 0, hi_len = 0;
   int vld_data = 0, vld_rdy = 0;
   logic p_sck = 1'b0, p_conv = 1'b0;
   logic [15:0] tx_word = 16'h0000, cur_w = 16'h0000;
   int k = 16;

   // monitor and converter model
   always @(negedge clk) begin
      cyc++;
      if (conv && !p_conv) begin
         conv_rise++; prev_rise_cyc = rise_cyc; rise_cyc = cyc;
      end
      if (!conv && p_conv) hi_len = cyc - rise_cyc;
      if (sck && !p_sck) sck_rise++;
      if (vld) begin vld_cnt++; vld_data = int'(data); vld_rdy = int'(rdy); end
      if ((p_sck && !sck) || (!p_conv && conv)) begin
         if (conv) begin k = 0; cur_w = tx_word; end
         else if (k < 16) k++;
         sdo = (k < 16) ? cur_w[15-k] : 1'b0;
      end
      p_sck = sck; p_conv = conv;
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_valids(input int n, input string rq);
      int start = vld_cnt;
      int t = 0;
      while (vld_cnt < start + n && t < 1000) begin @(negedge clk); t++; end
      chk(vld_cnt >= start + n, rq, "valid strobes seen", vld_cnt - start, n);
   endtask

   task automatic wait_rise(input int tmo);
      int c = conv_rise;
      int t = 0;
      while (conv_rise == c && t < tmo) begin @(negedge clk); t++; end
   endtask

   task automatic wait_mode(input logic [1:0] m);
      int t = 0;
      while (mode != m && t < 500) begin @(negedge clk); t++; end
   endtask

   function automatic int smp_of(input logic [15:0] w);
      return int'(w[13:2]);
   endfunction

   task automatic t_reset();
      wait_cyc(4);
      // R1
      chk(!sck && !conv && !vld, "R1", "outputs low in reset", int'({sck, conv, vld}), 0);
      chk(mode == 2'd0, "R1", "mode in reset", int'(mode), 0);
      rst_n = 1'b1;
      wait_cyc(2);
   endtask

   task automatic t_frames();
      logic [15:0] pats [3] = '{16'h2971, 16'hC006, 16'h3FFE};
      run = 1'b1;
      foreach (pats[i]) begin
         tx_word = pats[i];
         wait_valids(2, "R3");
         // R3 field extraction
         chk(vld_data == smp_of(pats[i]), "R3", "sample field", vld_data, smp_of(pats[i]));
         chk(vld_rdy == int'(pats[i][1]), "R3", "ready flag", vld_rdy, int'(pats[i][1]));
      end
      // R2 frame spacing and strobe width
      chk(rise_cyc - prev_rise_cyc == FRM, "R2", "start spacing", rise_cyc - prev_rise_cyc, FRM);
      chk(hi_len == PER, "R2", "start strobe width", hi_len, PER);
   endtask

   task automatic t_stop();
      int v0, c0;
      tx_word = 16'h1554;
      wait_rise(200);
      wait_cyc(20);
      v0 = vld_cnt; c0 = conv_rise;
      run = 1'b0;
      wait_cyc(300);
      // R4
      chk(vld_cnt - v0 == 1, "R4", "frame in flight delivered", vld_cnt - v0, 1);
      chk(conv_rise == c0, "R4", "no start after stop", conv_rise - c0, 0);
      chk(vld_data == smp_of(16'h1554), "R4", "last sample", vld_data, smp_of(16'h1554));
   endtask

   task automatic t_nap();
      int v0, c0, s1, c1, t0;
      run = 1'b1;
      tx_word = 16'h0ABC;
      wait_rise(200);
      wait_cyc(10);
      v0 = vld_cnt; c0 = conv_rise;
      preq = 2'd1;
      wait_mode(2'd1);
      // R10
      chk(vld_cnt - v0 == 1, "R10", "frame finished before burst", vld_cnt - v0, 1);
      // R5
      chk(conv_rise - c0 == 2, "R5", "nap pulse count", conv_rise - c0, 2);
      chk(hi_len == PER, "R5", "nap pulse width", hi_len, PER);
      chk(rise_cyc - prev_rise_cyc == 2 * PER, "R5", "nap pulse spacing",
          rise_cyc - prev_rise_cyc, 2 * PER);
      chk(mode == 2'd1, "R5", "mode after nap burst", int'(mode), 1);
      s1 = sck_rise; c1 = conv_rise;
      preq = 2'd2;
      wait_cyc(300);
      // R7
      chk(sck_rise == s1 && conv_rise == c1, "R7", "lines quiet in nap",
          (sck_rise - s1) + (conv_rise - c1), 0);
      chk(mode == 2'd1, "R7", "other low mode ignored", int'(mode), 1);
      preq = 2'd0;
      t0 = cyc;
      wait_rise(2000);
      // R8
      chk(rise_cyc - t0 >= NAP_W && rise_cyc - t0 <= NAP_W + 10, "R8",
          "nap wake delay", rise_cyc - t0, NAP_W);
      chk(mode == 2'd0, "R8", "mode after nap wake", int'(mode), 0);
      wait_valids(1, "R8");
      chk(vld_data == smp_of(16'h0ABC), "R8", "sample after nap", vld_data, smp_of(16'h0ABC));
   endtask

   task automatic t_sleep();
      int c0, t0, v0;
      tx_word = 16'h2971;
      wait_rise(200);
      wait_cyc(10);
      c0 = conv_rise;
      preq = 2'd2;
      wait_mode(2'd2);
      // R6
      chk(conv_rise - c0 == 4, "R6", "sleep pulse count", conv_rise - c0, 4);
      chk(hi_len == PER, "R6", "sleep pulse width", hi_len, PER);
      chk(mode == 2'd2, "R6", "mode after sleep burst", int'(mode), 2);
      preq = 2'd3;
      t0 = cyc;
      wait_rise(3000);
      // R11 wake by code 3, R8 deep wake delay
      chk(rise_cyc - t0 >= SLEEP_W && rise_cyc - t0 <= SLEEP_W + 10, "R8",
          "sleep wake delay", rise_cyc - t0, SLEEP_W);
      chk(mode == 2'd0, "R11", "code 3 wakes", int'(mode), 0);
      v0 = vld_cnt;
      wait_cyc(4 * FRM);
      // R9
      chk(vld_cnt == v0, "R9", "unsettled frames held back", vld_cnt - v0, 0);
      tx_word = 16'h3FFE;
      wait_valids(1, "R9");
      chk(vld_data == smp_of(16'h3FFE) && vld_rdy == 1, "R9", "first settled frame",
          vld_data, smp_of(16'h3FFE));
      tx_word = 16'h1554;
      wait_valids(2, "R9");
      chk(vld_data == smp_of(16'h1554) && vld_rdy == 0, "R9", "gate stays open",
          vld_data, smp_of(16'h1554));
   endtask

   task automatic t_code3();
      int c0, v0;
      c0 = conv_rise; v0 = vld_cnt;
      preq = 2'd3;
      wait_cyc(5 * FRM);
      // R11
      chk(mode == 2'd0, "R11", "code 3 while active", int'(mode), 0);
      chk(vld_cnt - v0 >= 4, "R11", "frames continue", vld_cnt - v0, 4);
      chk(rise_cyc - prev_rise_cyc == FRM, "R11", "no burst", rise_cyc - prev_rise_cyc, FRM);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_frames();
      t_stop();
      t_nap();
      t_sleep();
      t_code3();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule